// File: doc/BRIEF.md
# Compact 32-bit Multi-Cycle Processor Core

This block is a small 32-bit processor that runs eleven instructions over one unified, word-addressed memory. It holds a program counter, sixteen general registers, an instruction register and an execute unit. The execute unit adds and NANDs, sign-extends the 20-bit immediate, forms PC-relative targets and compares two registers as signed numbers. There are no condition codes: the two conditional branches compare two registers directly. The core reaches memory through one synchronous port. An address presented in one cycle returns its word on `mem_rdata` in the next cycle, and a write is committed at the clock edge where `mem_wr` is high.

Each instruction is run by a state machine with five named states. `ST_FETCH` drives the PC onto the address bus. `ST_DECODE` captures the returned word into the instruction register and increments the PC. `ST_EXEC` reads the registers and does one of three things: it writes back a result, it drives the load or store address, or it loads a new PC. `ST_LOAD` writes the returned memory word into the destination register. `ST_HALT` is a terminal state.

The transitions are:
- FETCH→DECODE: always.
- DECODE→EXEC: always.
- EXEC→LOAD: for a load.
- EXEC→HALT: for a halt.
- EXEC→FETCH: for every other instruction.
- LOAD→FETCH: always.
- HALT→HALT: always.

A load therefore takes four cycles and every other instruction takes three. Only reset leaves `ST_HALT`.

Top module: `mini_core`

## Requirements
- R1: While reset is held, `halted` is 0, `mem_wr` is 0 and `mem_addr` is 0. After release, the first instruction is fetched from address 0 and all registers start at 0.
- R2: An instruction word is split into fields as follows. Bits [31:28] are the opcode. Bits [27:24] are the destination register, or the store source. Bits [23:20] are the first source or base register. Bits [3:0] are the second source of the register-register operations. Bits [19:0] are the immediate. The opcodes are: add 0, nand 1, add-immediate 2, load 3, store 4, branch 5, jump-and-link 6, halt 7, branch-if-less 8, branch-if-greater 9, load-address 10. Add writes the 32-bit sum of the two sources to the destination, and nand writes the bitwise NOT of their AND.
- R3: Add-immediate, load and store sign-extend bits [19:0] from bit 19 and add the result to the register in [23:20]. Add-immediate writes this sum to the destination. Load reads memory at the sum into the destination, and store writes the [27:24] register to memory at the sum.
- R4: Only the low 16 bits of a computed address reach `mem_addr`. A base value of 0x10100 accesses word 0x0100.
- R5: Register 0 always reads as 0. Writes to it have no effect.
- R6: Branch and load-address add the sign-extended offset to the incremented PC (the instruction address plus 1). Branch jumps to that value, and load-address writes it to the destination.
- R7: Branch-if-less is taken when the [27:24] register is less than the [23:20] register, and branch-if-greater when it is greater. Both compare as signed 32-bit numbers. A branch that is not taken continues at PC+1.
- R8: Jump-and-link writes the incremented PC to the [27:24] register and jumps to the value the [23:20] register held before that write, including when the two fields name the same register.
- R9: After a halt is executed, `halted` rises and stays high until reset. No later instruction runs and no memory write occurs.
- R10: Opcodes 11 to 15 change no register and no memory word. They only advance the PC by one.
- R11: The PC increases by exactly one in the decode cycle of every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_wr | output | 1 | Write strobe, commits `mem_wdata` at the edge |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Word read at the address of the previous cycle |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Some behaviours are checked by assertions on every cycle:
- the PC increments once per decode;
- a jump-and-link lands on the old source value, even when the link overwrites that register;
- a branch that is not taken leaves the incremented PC in place;
- the halt state is sticky, and no write strobe appears while halted.

Other behaviours only the bench scenarios can show. These are the arithmetic results, the signed compare when operands differ in sign or are equal, the sign extension of the immediate, the 16-bit address wrap, the zero register, the PC-relative targets and the unused opcodes acting as no-ops. The bench runs small programs and inspects the memory words they leave behind.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int unsigned IMM_W  = 20;
    localparam int unsigned RSEL_W = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_NAND = 4'd1,
        OP_ADDI = 4'd2,
        OP_LW   = 4'd3,
        OP_SW   = 4'd4,
        OP_BR   = 4'd5,
        OP_JALR = 4'd6,
        OP_HALT = 4'd7,
        OP_BLT  = 4'd8,
        OP_BGT  = 4'd9,
        OP_LEA  = 4'd10
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD,
        ST_HALT
    } state_e;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rsel_a,
    input  logic [$clog2(NREG)-1:0] rsel_b,
    output logic [XLEN-1:0]         rval_a,
    output logic [XLEN-1:0]         rval_b,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wsel,
    input  logic [XLEN-1:0]         wval
);

    logic [XLEN-1:0] regs [NREG];

    // entry 0 is cleared by reset and never written afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
        end else if (wr_en && (wsel != '0)) begin
            regs[wsel] <= wval;
        end
    end

    assign rval_a = regs[rsel_a];
    assign rval_b = regs[rsel_b];

endmodule

// File: rtl/mc_exec_unit.sv
module mc_exec_unit
    import mc_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned AW   = 16
) (
    input  opcode_e             op,
    input  logic [XLEN-1:0]     src_a,
    input  logic [XLEN-1:0]     src_b,
    input  logic [IMM_W-1:0]    imm,
    input  logic [XLEN-1:0]     pc_inc,
    output logic [XLEN-1:0]     wb_val,
    output logic [AW-1:0]       mem_word,
    output logic [XLEN-1:0]     next_pc,
    output logic                taken
);

    localparam int unsigned EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] base_sum;
    logic [XLEN-1:0] rel_tgt;
    logic            b_lt_a;
    logic            b_gt_a;

    assign imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign base_sum = src_a + imm_ext;
    assign rel_tgt  = pc_inc + imm_ext;
    assign b_lt_a   = $signed(src_b) < $signed(src_a);
    assign b_gt_a   = $signed(src_b) > $signed(src_a);
    assign mem_word = base_sum[AW-1:0];

    always_comb begin
        wb_val  = '0;
        next_pc = pc_inc;
        taken   = 1'b0;
        case (op)
            OP_ADD:  wb_val = src_a + src_b;
            OP_NAND: wb_val = ~(src_a & src_b);
            OP_ADDI: wb_val = base_sum;
            OP_LEA:  wb_val = rel_tgt;
            OP_BR: begin
                taken   = 1'b1;
                next_pc = rel_tgt;
            end
            OP_JALR: begin
                wb_val  = pc_inc;
                taken   = 1'b1;
                next_pc = src_a;
            end
            OP_BLT: begin
                taken   = b_lt_a;
                next_pc = b_lt_a ? rel_tgt : pc_inc;
            end
            OP_BGT: begin
                taken   = b_gt_a;
                next_pc = b_gt_a ? rel_tgt : pc_inc;
            end
            default: begin
                wb_val  = '0;
                next_pc = pc_inc;
            end
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    output state_e  state,
    output logic    fetch_phase,
    output logic    ir_load,
    output logic    exec_phase,
    output logic    load_phase,
    output logic    halted
);

    state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_LW)        state_nx = ST_LOAD;
                else if (op == OP_HALT) state_nx = ST_HALT;
                else                    state_nx = ST_FETCH;
            end
            ST_LOAD:   state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        fetch_phase = 1'b0;
        ir_load     = 1'b0;
        exec_phase  = 1'b0;
        load_phase  = 1'b0;
        halted      = 1'b0;
        unique case (state)
            ST_FETCH:  fetch_phase = 1'b1;
            ST_DECODE: ir_load     = 1'b1;
            ST_EXEC:   exec_phase  = 1'b1;
            ST_LOAD:   load_phase  = 1'b1;
            ST_HALT:   halted      = 1'b1;
            default:   fetch_phase = 1'b0;
        endcase
    end

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));

    // R11
    decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

endmodule

// File: rtl/mini_core.sv
module mini_core
    import mc_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted
);

    localparam int unsigned RW = $clog2(NREG);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] ir;
    opcode_e         op;
    state_e          state;
    logic            fetch_phase, ir_load, exec_phase, load_phase;

    logic [RW-1:0]   f_dst, f_src1, f_src2, sel_b;
    logic [XLEN-1:0] val_a, val_b;
    logic [XLEN-1:0] wb_val, next_pc;
    logic [AW-1:0]   data_word;
    logic            taken;
    logic            rf_we;
    logic [XLEN-1:0] rf_wval;
    logic            op_writes;

    assign op     = opcode_e'(ir[31:28]);
    assign f_dst  = ir[24 +: RW];
    assign f_src1 = ir[20 +: RW];
    assign f_src2 = ir[0  +: RW];

    // register-register ops read the second source from the low field,
    // stores and compares read the destination field instead
    assign sel_b = (op == OP_ADD || op == OP_NAND) ? f_src2 : f_dst;

    mc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .state      (state),
        .fetch_phase(fetch_phase),
        .ir_load    (ir_load),
        .exec_phase (exec_phase),
        .load_phase (load_phase),
        .halted     (halted)
    );

    mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .rsel_a(f_src1),
        .rsel_b(sel_b),
        .rval_a(val_a),
        .rval_b(val_b),
        .wr_en (rf_we),
        .wsel  (f_dst),
        .wval  (rf_wval)
    );

    mc_exec_unit #(.XLEN(XLEN), .AW(AW)) u_ex (
        .op      (op),
        .src_a   (val_a),
        .src_b   (val_b),
        .imm     (ir[IMM_W-1:0]),
        .pc_inc  (pc),
        .wb_val  (wb_val),
        .mem_word(data_word),
        .next_pc (next_pc),
        .taken   (taken)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_NAND, OP_ADDI, OP_JALR, OP_LEA: op_writes = 1'b1;
            default:                                    op_writes = 1'b0;
        endcase
    end

    assign rf_we   = (exec_phase && op_writes) || load_phase;
    assign rf_wval = load_phase ? mem_rdata : wb_val;

    assign mem_addr  = fetch_phase ? pc[AW-1:0] : data_word;
    assign mem_wr    = exec_phase && (op == OP_SW);
    assign mem_wdata = val_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (ir_load) begin
                ir <= mem_rdata;
                pc <= pc + 1'b1;
            end else if (exec_phase) begin
                pc <= next_pc;
            end
        end
    end

    // R11
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> (pc == $past(pc) + 1'b1));

    // R8
    jalr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_phase && op == OP_JALR) |=> (pc == $past(val_a)));

    // R7
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_phase && (op == OP_BLT || op == OP_BGT) && !taken) |=> (pc == $past(pc)));

    // R9
    no_write_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_wr);

    // R9
    pc_frozen_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(pc));

endmodule

// File: tb/sim_mini_core.sv
`timescale 1ns/1ps
module sim_mini_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_wr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        halted;

    always #2 clk = ~clk;

    mini_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .halted   (halted)
    );

    // bench memory with a private preload port
    logic [31:0] mem [1024];
    logic        ld_en = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        clr = 1'b0;
    int          post_halt_wr;
    int          oob_acc;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
        if (clr) begin
            post_halt_wr <= 0;
            oob_acc      <= 0;
        end else begin
            if (halted && mem_wr) post_halt_wr <= post_halt_wr + 1;
            if (mem_wr && mem_addr >= 16'd1024) oob_acc <= oob_acc + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 199000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<199000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] d,
                                        input logic [3:0] s, input logic [19:0] imm);
        return {op, d, s, imm};
    endfunction

    function automatic logic [31:0] sext20(input logic [19:0] v);
        return {{12{v[19]}}, v};
    endfunction

    function automatic logic [31:0] cmp_code(input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        r = 0;
        if (!($signed(x) < $signed(y))) r = r + 1;
        if (!($signed(x) > $signed(y))) r = r + 2;
        return r;
    endfunction

    task automatic put(input int a, input logic [31:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a[9:0];
        ld_data = d;
    endtask

    task automatic put_done();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        rst_n = 1'b0;
        clr   = 1'b1;
        for (int i = 0; i < 1024; i++) put(i, 32'h0);
        put_done();
        clr = 1'b0;
    endtask

    task automatic launch(input string tag);
        int waited;
        @(negedge clk);
        // R1: reset state seen while reset is held
        chk("R1 halted in reset", {31'b0, halted}, 32'h0);
        chk("R1 mem_wr in reset", {31'b0, mem_wr}, 32'h0);
        chk("R1 mem_addr in reset", {16'b0, mem_addr}, 32'h0);
        rst_n = 1'b1;
        waited = 0;
        while (!halted && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!halted) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 %s: halted actual=0 expected=1", tag);
        end
        repeat (12) @(negedge clk);
        chk("R9 halted stays high", {31'b0, halted}, 32'h1);
        chk("R9 no write after halt", post_halt_wr, 32'h0);
        chk("R4 accesses stay in window", oob_acc, 32'h0);
    endtask

    initial begin
        logic [31:0] a, b;
        logic [19:0] im;
        void'($urandom(32'd20240607));

        // randomized arithmetic, compare and sign-extension runs
        for (int it = 0; it < 10; it++) begin
            a  = $urandom;
            b  = $urandom;
            im = 20'($urandom);
            if (it == 0) b = a;
            if (it == 1) begin a = 32'hFFFF_FFF0; b = 32'h0000_0010; end
            if (it == 2) begin a = 32'h7FFF_FFFF; b = 32'h8000_0000; end
            if (it == 3) im = 20'h80000;
            wipe();
            put(0,  enc(4'd3, 4'd1, 4'd0, 20'h200));
            put(1,  enc(4'd3, 4'd2, 4'd0, 20'h201));
            put(2,  enc(4'd0, 4'd3, 4'd1, 20'h2));
            put(3,  enc(4'd1, 4'd4, 4'd1, 20'h2));
            put(4,  enc(4'd2, 4'd5, 4'd1, im));
            put(5,  enc(4'd4, 4'd3, 4'd0, 20'h300));
            put(6,  enc(4'd4, 4'd4, 4'd0, 20'h301));
            put(7,  enc(4'd4, 4'd5, 4'd0, 20'h302));
            put(8,  enc(4'd2, 4'd6, 4'd0, 20'h0));
            put(9,  enc(4'd8, 4'd1, 4'd2, 20'h1));
            put(10, enc(4'd2, 4'd6, 4'd6, 20'h1));
            put(11, enc(4'd9, 4'd1, 4'd2, 20'h1));
            put(12, enc(4'd2, 4'd6, 4'd6, 20'h2));
            put(13, enc(4'd4, 4'd6, 4'd0, 20'h303));
            put(14, enc(4'd7, 4'd0, 4'd0, 20'h0));
            put(15, enc(4'd4, 4'd1, 4'd0, 20'h304));
            put(16'h200, a);
            put(16'h201, b);
            put_done();
            launch("random");
            chk("R2 add", mem[10'h300], a + b);
            chk("R2 nand", mem[10'h301], ~(a & b));
            chk("R3 addi sign-extended", mem[10'h302], a + sext20(im));
            chk("R7 signed compare", mem[10'h303], cmp_code(a, b));
            chk("R9 code after halt skipped", mem[10'h304], 32'h0);
        end

        // directed corner cases
        wipe();
        put(0,  enc(4'd2, 4'd0, 4'd0, 20'h5));      // r0 <- 5 (discarded)
        put(1,  enc(4'd4, 4'd0, 4'd0, 20'h310));
        put(2,  enc(4'd2, 4'd7, 4'd0, 20'h10));     // r7 = 16
        put(3,  enc(4'd6, 4'd7, 4'd7, 20'h0));      // link into r7, jump via old r7
        put(4,  enc(4'd7, 4'd0, 4'd0, 20'h0));
        put(16, enc(4'd4, 4'd7, 4'd0, 20'h311));
        put(17, enc(4'd10, 4'd8, 4'd0, 20'h5));     // r8 = 18 + 5
        put(18, enc(4'd4, 4'd8, 4'd0, 20'h312));
        put(19, enc(4'd5, 4'd0, 4'd0, 20'h2));      // to 22
        put(20, enc(4'd2, 4'd9, 4'd0, 20'h1));
        put(21, enc(4'd2, 4'd9, 4'd0, 20'h1));
        put(22, 32'hB900_0001);                     // unused opcode
        put(23, enc(4'd4, 4'd9, 4'd0, 20'h313));
        put(24, enc(4'd2, 4'd10, 4'd0, 20'h10100));
        put(25, enc(4'd2, 4'd11, 4'd0, 20'h77));
        put(26, enc(4'd4, 4'd11, 4'd10, 20'h0));    // address wraps to 0x100
        put(27, enc(4'd3, 4'd12, 4'd0, 20'h100));
        put(28, enc(4'd4, 4'd12, 4'd0, 20'h314));
        put(29, 32'hF000_0000);                     // unused opcode, all-zero fields
        put(30, enc(4'd2, 4'd13, 4'd0, 20'hFFFFF));
        put(31, enc(4'd4, 4'd13, 4'd0, 20'h316));
        put(32, enc(4'd7, 4'd0, 4'd0, 20'h0));
        put(33, enc(4'd4, 4'd11, 4'd0, 20'h315));
        put_done();
        launch("directed");
        chk("R5 zero register", mem[10'h310], 32'h0);
        chk("R8 link value with same register", mem[10'h311], 32'h4);
        chk("R6 load-address target", mem[10'h312], 32'd23);
        chk("R6 branch skipped two words", mem[10'h313], 32'h0);
        chk("R10 unused opcode left r9", mem[10'h313], 32'h0);
        chk("R4 truncated store", mem[10'h100], 32'h77);
        chk("R3 load at offset", mem[10'h314], 32'h77);
        chk("R3 negative immediate", mem[10'h316], 32'hFFFF_FFFF);
        chk("R9 store after halt", mem[10'h315], 32'h0);
        chk("R10 instruction word intact", mem[10'd22], 32'hB900_0001);

        summary();
        $finish;
    end

endmodule